// File: doc/BRIEF.md
# Prioritized Interrupt Source Poller

Several devices share one interrupt request line. This block works out which of them raised it. It holds a table of entries, each describing one device. An entry names which device status byte to look at, an inversion byte and a select byte for that status, an 8-bit rank, and a service index that software uses to dispatch the handler. When the interrupt line is sampled high, every entry is tested against the status bytes present in that cycle. The block reports the entry that comes first in poll order: highest rank first, with equal ranks taken in ascending slot order. If no entry claims the interrupt, the block reports a spurious interrupt instead.

Software fills the table through a write port. Each write goes to the lowest-numbered free slot, and the slot used is reported back. A write to a full table is refused and flagged. A separate retire input frees a slot, so that entry is skipped from then on and the slot can be reused.

Top module: `irq_poller`

## Requirements
- R1: After synchronous reset every slot is free and all outputs are 0. The first interrupt after reset reports spurious.
- R2: An entry claims the interrupt when ((status byte XOR flip) AND mask) is non-zero. Status byte d is dev_status[8*d+7:8*d], and the entry's device select picks d. A flip bit of 1 makes the corresponding status bit count as active when it is 0.
- R3: Among claiming entries, the one with the numerically largest rank is reported (rank 0 lowest, 255 highest).
- R4: Among claiming entries of equal highest rank, the one in the lowest slot index is reported.
- R5: Free slots never claim an interrupt, whatever their stale fields hold.
- R6: When no entry claims, hit_spurious pulses and hit_valid stays 0. hit_svc and hit_slot read 0 with a spurious result, and the two pulses are never high together.
- R7: tw_en stores the entry in the lowest free slot. One cycle later tw_ack pulses with tw_slot giving that slot.
- R8: tw_en with no free slot pulses tw_err one cycle later and leaves the table unchanged.
- R9: A result (hit_valid or hit_spurious) is a one-cycle pulse two clock edges after the edge that samples irq high. Every sampled interrupt yields exactly one result.
- R10: The result depends only on dev_status and the table as sampled at the irq edge. Status changes afterwards do not alter it.
- R11: td_en frees slot td_slot. A later write reuses the lowest free slot, including that one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Shared interrupt request, sampled each edge |
| dev_status | input | 8*N_DEV | Device status bytes, byte d at [8d+7:8d] |
| tw_en | input | 1 | Store a new entry |
| tw_dev | input | DEV_W | Device select of new entry |
| tw_flip | input | 8 | Polarity inversion byte |
| tw_mask | input | 8 | Status bit select byte |
| tw_prio | input | 8 | Rank, 255 highest |
| tw_svc | input | SVC_W | Service index |
| td_en | input | 1 | Free a slot |
| td_slot | input | SLOT_W | Slot to free |
| tw_ack | output | 1 | Write stored (pulse) |
| tw_err | output | 1 | Write refused, table full (pulse) |
| tw_slot | output | SLOT_W | Slot used by the acknowledged write |
| hit_valid | output | 1 | A source was found (pulse) |
| hit_spurious | output | 1 | No source claimed the interrupt (pulse) |
| hit_svc | output | SVC_W | Service index of the winning entry |
| hit_slot | output | SLOT_W | Slot of the winning entry |

## Verification
The bench polls an active-low source, which a design that forgets the flip byte would miss or report when idle. It makes a high-rank and a low-rank entry claim together, and two equal-rank entries claim together, which catches a search that keeps the last match or compares ranks the wrong way round. It changes the status one cycle after the interrupt, so a design that samples late reports the wrong entry. It retires a slot, refills it, then overfills the table. This exposes a stale entry still answering, a wrong slot choice on reuse, and a refused write that silently overwrites a slot.

// File: rtl/irq_poll_pkg.sv
package irq_poll_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_entry_table.sv
module irq_entry_table
  import irq_poll_pkg::*;
#(
  parameter int N_ENT  = 8,
  parameter int DEV_W  = 2,
  parameter int SVC_W  = 8,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DEV_W-1:0]  wr_dev,
  input  byte_t             wr_flip,
  input  byte_t             wr_mask,
  input  byte_t             wr_prio,
  input  logic [SVC_W-1:0]  wr_svc,
  input  logic              rm_en,
  input  logic [SLOT_W-1:0] rm_slot,
  output logic              wr_ack,
  output logic              wr_err,
  output logic [SLOT_W-1:0] wr_slot,
  output logic              full,
  output logic              ent_vld  [N_ENT],
  output logic [DEV_W-1:0]  ent_dev  [N_ENT],
  output byte_t             ent_flip [N_ENT],
  output byte_t             ent_mask [N_ENT],
  output byte_t             ent_prio [N_ENT],
  output logic [SVC_W-1:0]  ent_svc  [N_ENT]
);
  logic              free_found;
  logic [SLOT_W-1:0] free_idx;

  always_comb begin
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (!ent_vld[i] && !free_found) begin
        free_found = 1'b1;
        free_idx   = SLOT_W'(i);
      end
    end
  end

  assign full = !free_found;

  // Entry fields carry no reset: only the valid bits gate their use.
  always_ff @(posedge clk) begin
    if (wr_en && free_found) begin
      ent_dev[free_idx]  <= wr_dev;
      ent_flip[free_idx] <= wr_flip;
      ent_mask[free_idx] <= wr_mask;
      ent_prio[free_idx] <= wr_prio;
      ent_svc[free_idx]  <= wr_svc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_ENT; i++) ent_vld[i] <= 1'b0;
      wr_ack  <= 1'b0;
      wr_err  <= 1'b0;
      wr_slot <= '0;
    end else begin
      wr_ack <= 1'b0;
      wr_err <= 1'b0;
      if (rm_en && (int'(rm_slot) < N_ENT)) ent_vld[rm_slot] <= 1'b0;
      if (wr_en) begin
        if (free_found) begin
          ent_vld[free_idx] <= 1'b1;
          wr_ack  <= 1'b1;
          wr_slot <= free_idx;
        end else begin
          wr_err <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/irq_match_unit.sv
module irq_match_unit
  import irq_poll_pkg::*;
#(
  parameter int N_ENT = 8,
  parameter int N_DEV = 4,
  parameter int DEV_W = 2
) (
  input  logic [BYTE_W*N_DEV-1:0] status,
  input  logic                    ent_vld  [N_ENT],
  input  logic [DEV_W-1:0]        ent_dev  [N_ENT],
  input  byte_t                   ent_flip [N_ENT],
  input  byte_t                   ent_mask [N_ENT],
  output logic [N_ENT-1:0]        claim
);
  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    byte_t picked;
    always_comb begin
      picked = '0;
      for (int d = 0; d < N_DEV; d++)
        if (int'(ent_dev[g]) == d) picked = status[BYTE_W*d +: BYTE_W];
    end
    assign claim[g] = ent_vld[g] && (|((picked ^ ent_flip[g]) & ent_mask[g]));
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_poll_pkg::*;
#(
  parameter int N_ENT  = 8,
  parameter int SLOT_W = 3
) (
  input  logic [N_ENT-1:0]  claim,
  input  byte_t             prio [N_ENT],
  output logic              found,
  output logic [SLOT_W-1:0] win
);
  byte_t best;

  // Strict greater-than keeps the lower slot on equal rank.
  always_comb begin
    found = 1'b0;
    win   = '0;
    best  = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (claim[i] && (!found || prio[i] > best)) begin
        found = 1'b1;
        win   = SLOT_W'(i);
        best  = prio[i];
      end
    end
  end
endmodule

// File: rtl/irq_poller.sv
module irq_poller
  import irq_poll_pkg::*;
#(
  parameter  int N_ENT  = 8,
  parameter  int N_DEV  = 4,
  parameter  int SVC_W  = 8,
  localparam int SLOT_W = irq_poll_pkg::idx_w(N_ENT),
  localparam int DEV_W  = irq_poll_pkg::idx_w(N_DEV)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  irq,
  input  logic [8*N_DEV-1:0]    dev_status,
  input  logic                  tw_en,
  input  logic [DEV_W-1:0]      tw_dev,
  input  logic [7:0]            tw_flip,
  input  logic [7:0]            tw_mask,
  input  logic [7:0]            tw_prio,
  input  logic [SVC_W-1:0]      tw_svc,
  input  logic                  td_en,
  input  logic [SLOT_W-1:0]     td_slot,
  output logic                  tw_ack,
  output logic                  tw_err,
  output logic [SLOT_W-1:0]     tw_slot,
  output logic                  hit_valid,
  output logic                  hit_spurious,
  output logic [SVC_W-1:0]      hit_svc,
  output logic [SLOT_W-1:0]     hit_slot
);
  logic              ent_vld  [N_ENT];
  logic [DEV_W-1:0]  ent_dev  [N_ENT];
  byte_t             ent_flip [N_ENT];
  byte_t             ent_mask [N_ENT];
  byte_t             ent_prio [N_ENT];
  logic [SVC_W-1:0]  ent_svc  [N_ENT];
  logic              tbl_full;
  logic [N_ENT-1:0]  claim;
  logic              pick_found;
  logic [SLOT_W-1:0] pick_slot;

  logic              s1_go, s1_found;
  logic [SLOT_W-1:0] s1_slot;
  logic [SVC_W-1:0]  s1_svc;

  irq_entry_table #(
    .N_ENT(N_ENT), .DEV_W(DEV_W), .SVC_W(SVC_W), .SLOT_W(SLOT_W)
  ) u_table (
    .clk(clk), .rst(rst),
    .wr_en(tw_en), .wr_dev(tw_dev), .wr_flip(tw_flip), .wr_mask(tw_mask),
    .wr_prio(tw_prio), .wr_svc(tw_svc),
    .rm_en(td_en), .rm_slot(td_slot),
    .wr_ack(tw_ack), .wr_err(tw_err), .wr_slot(tw_slot), .full(tbl_full),
    .ent_vld(ent_vld), .ent_dev(ent_dev), .ent_flip(ent_flip),
    .ent_mask(ent_mask), .ent_prio(ent_prio), .ent_svc(ent_svc)
  );

  irq_match_unit #(
    .N_ENT(N_ENT), .N_DEV(N_DEV), .DEV_W(DEV_W)
  ) u_match (
    .status(dev_status), .ent_vld(ent_vld), .ent_dev(ent_dev),
    .ent_flip(ent_flip), .ent_mask(ent_mask), .claim(claim)
  );

  irq_prio_pick #(
    .N_ENT(N_ENT), .SLOT_W(SLOT_W)
  ) u_pick (
    .claim(claim), .prio(ent_prio), .found(pick_found), .win(pick_slot)
  );

  // Stage 1: decide against the status and table seen at the irq edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_go    <= 1'b0;
      s1_found <= 1'b0;
      s1_slot  <= '0;
      s1_svc   <= '0;
    end else begin
      s1_go    <= irq;
      s1_found <= irq && pick_found;
      s1_slot  <= pick_found ? pick_slot : '0;
      s1_svc   <= pick_found ? ent_svc[pick_slot] : '0;
    end
  end

  // Stage 2: registered result pulse.
  always_ff @(posedge clk) begin
    if (rst) begin
      hit_valid    <= 1'b0;
      hit_spurious <= 1'b0;
      hit_svc      <= '0;
      hit_slot     <= '0;
    end else begin
      hit_valid    <= s1_go && s1_found;
      hit_spurious <= s1_go && !s1_found;
      hit_svc      <= (s1_go && s1_found) ? s1_svc  : '0;
      hit_slot     <= (s1_go && s1_found) ? s1_slot : '0;
    end
  end
endmodule

// File: rtl/irq_poller_chk.sv
module irq_poller_chk #(
  parameter int SVC_W  = 8,
  parameter int SLOT_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              irq,
  input logic              tw_en,
  input logic              tw_ack,
  input logic              tw_err,
  input logic              tbl_full,
  input logic              hit_valid,
  input logic              hit_spurious,
  input logic [SVC_W-1:0]  hit_svc,
  input logic [SLOT_W-1:0] hit_slot
);
  p_one_kind_r6: assert property (@(posedge clk) disable iff (rst)
    !(hit_valid && hit_spurious));

  p_spur_zero_r6: assert property (@(posedge clk) disable iff (rst)
    hit_spurious |-> (hit_svc == '0 && hit_slot == '0));

  p_latency_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> ##2 (hit_valid || hit_spurious));

  p_no_stray_r9: assert property (@(posedge clk) disable iff (rst)
    (hit_valid || hit_spurious) |-> $past(irq, 2));

  p_wr_resp_r7: assert property (@(posedge clk) disable iff (rst)
    tw_en |=> (tw_ack != tw_err));

  p_ack_free_r7: assert property (@(posedge clk) disable iff (rst)
    tw_ack |-> !$past(tbl_full));

  p_full_err_r8: assert property (@(posedge clk) disable iff (rst)
    tw_err |-> $past(tbl_full));
endmodule

bind irq_poller irq_poller_chk #(.SVC_W(SVC_W), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .tw_en(tw_en), .tw_ack(tw_ack),
  .tw_err(tw_err), .tbl_full(tbl_full), .hit_valid(hit_valid),
  .hit_spurious(hit_spurious), .hit_svc(hit_svc), .hit_slot(hit_slot)
);

// File: tb/sim_irq_poller.sv
module sim_irq_poller;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq = 1'b0;
  logic [31:0] dev_status = '0;
  logic        tw_en = 1'b0;
  logic [1:0]  tw_dev = '0;
  logic [7:0]  tw_flip = '0, tw_mask = '0, tw_prio = '0, tw_svc = '0;
  logic        td_en = 1'b0;
  logic [2:0]  td_slot = '0;
  logic        tw_ack, tw_err, hit_valid, hit_spurious;
  logic [2:0]  tw_slot, hit_slot;
  logic [7:0]  hit_svc;

  int checks = 0;
  int errs   = 0;

  always #(CLK_NS/2) clk = ~clk;

  irq_poller #(.N_ENT(8), .N_DEV(4), .SVC_W(8)) u0 (
    .clk(clk), .rst(rst), .irq(irq), .dev_status(dev_status),
    .tw_en(tw_en), .tw_dev(tw_dev), .tw_flip(tw_flip), .tw_mask(tw_mask),
    .tw_prio(tw_prio), .tw_svc(tw_svc), .td_en(td_en), .td_slot(td_slot),
    .tw_ack(tw_ack), .tw_err(tw_err), .tw_slot(tw_slot),
    .hit_valid(hit_valid), .hit_spurious(hit_spurious),
    .hit_svc(hit_svc), .hit_slot(hit_slot)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(input logic [7:0] b0, b1, b2, b3);
    return {b3, b2, b1, b0};
  endfunction

  task automatic add(input logic [1:0] dev, input logic [7:0] flip, mask, prio, svc,
                     input logic exp_ok, input logic [2:0] exp_slot, input string req);
    @(negedge clk);
    tw_en = 1'b1; tw_dev = dev; tw_flip = flip; tw_mask = mask;
    tw_prio = prio; tw_svc = svc;
    @(negedge clk);
    tw_en = 1'b0;
    check({req, " ack"}, {31'd0, tw_ack}, {31'd0, exp_ok});
    check({req, " err"}, {31'd0, tw_err}, {31'd0, !exp_ok});
    if (exp_ok) check({req, " slot"}, {29'd0, tw_slot}, {29'd0, exp_slot});
  endtask

  task automatic retire(input logic [2:0] slot);
    @(negedge clk);
    td_en = 1'b1; td_slot = slot;
    @(negedge clk);
    td_en = 1'b0;
  endtask

  task automatic poll(input logic [31:0] st, input logic [31:0] st_after,
                      input logic exp_v, input logic [7:0] exp_svc,
                      input logic [2:0] exp_slot, input string req);
    @(negedge clk);
    irq = 1'b1; dev_status = st;
    @(negedge clk);
    irq = 1'b0; dev_status = st_after;
    check({req, " R9 no early result"}, {30'd0, hit_valid, hit_spurious}, 32'd0);
    @(negedge clk);
    check({req, " valid"}, {31'd0, hit_valid}, {31'd0, exp_v});
    check({req, " R6 spurious"}, {31'd0, hit_spurious}, {31'd0, !exp_v});
    check({req, " svc"}, {24'd0, hit_svc}, exp_v ? {24'd0, exp_svc} : 32'd0);
    check({req, " slot"}, {29'd0, hit_slot}, exp_v ? {29'd0, exp_slot} : 32'd0);
    @(negedge clk);
    check({req, " R9 one-cycle pulse"}, {30'd0, hit_valid, hit_spurious}, 32'd0);
  endtask

  task automatic t_reset;
    check("R1 reset ack/err", {30'd0, tw_ack, tw_err}, 32'd0);
    check("R1 reset result", {30'd0, hit_valid, hit_spurious}, 32'd0);
    poll(pack(8'hFF, 8'hFF, 8'hFF, 8'hFF), '0, 1'b0, 8'h0, 3'd0, "R1 empty table");
  endtask

  task automatic t_fill;
    add(2'd0, 8'h00, 8'h01, 8'd10,  8'hA0, 1'b1, 3'd0, "R7 e0");
    add(2'd1, 8'h80, 8'h80, 8'd50,  8'hA1, 1'b1, 3'd1, "R7 e1 active-low");
    add(2'd2, 8'h00, 8'h0C, 8'd50,  8'hA2, 1'b1, 3'd2, "R7 e2");
    add(2'd0, 8'h00, 8'h02, 8'd200, 8'hA3, 1'b1, 3'd3, "R7 e3");
  endtask

  task automatic t_match;
    poll(pack(8'h00, 8'h80, 8'h00, 8'h00), pack(8'h00, 8'h80, 8'h00, 8'h00),
         1'b0, 8'h0, 3'd0, "R6 idle no claim");
    poll(pack(8'h01, 8'h80, 8'h00, 8'h00), pack(8'h01, 8'h80, 8'h00, 8'h00),
         1'b1, 8'hA0, 3'd0, "R2 active-high");
    poll(pack(8'h00, 8'h00, 8'h00, 8'h00), pack(8'h00, 8'h80, 8'h00, 8'h00),
         1'b1, 8'hA1, 3'd1, "R2 active-low flip");
  endtask

  task automatic t_order;
    poll(pack(8'h03, 8'h80, 8'h00, 8'h00), pack(8'h00, 8'h80, 8'h00, 8'h00),
         1'b1, 8'hA3, 3'd3, "R3 highest rank");
    poll(pack(8'h00, 8'h00, 8'h04, 8'h00), pack(8'h00, 8'h80, 8'h00, 8'h00),
         1'b1, 8'hA1, 3'd1, "R4 tie low slot");
  endtask

  task automatic t_sample;
    poll(pack(8'h01, 8'h80, 8'h00, 8'h00), pack(8'h02, 8'h80, 8'h00, 8'h00),
         1'b1, 8'hA0, 3'd0, "R10 late status change");
  endtask

  task automatic t_retire;
    retire(3'd3);
    poll(pack(8'h03, 8'h80, 8'h00, 8'h00), pack(8'h00, 8'h80, 8'h00, 8'h00),
         1'b1, 8'hA0, 3'd0, "R5 retired skipped");
    add(2'd3, 8'h00, 8'hFF, 8'd255, 8'hB3, 1'b1, 3'd3, "R11 reuse slot");
    poll(pack(8'h01, 8'h80, 8'h00, 8'h01), pack(8'h00, 8'h80, 8'h00, 8'h00),
         1'b1, 8'hB3, 3'd3, "R11 reused entry");
  endtask

  task automatic t_full;
    for (int i = 4; i < 8; i++)
      add(2'd3, 8'h00, 8'h00, 8'd1, 8'hC0 + 8'(i), 1'b1, 3'(i), "R7 filler");
    add(2'd2, 8'h00, 8'hFF, 8'd255, 8'hEE, 1'b0, 3'd0, "R8 full");
    poll(pack(8'h00, 8'h80, 8'h10, 8'h00), pack(8'h00, 8'h80, 8'h00, 8'h00),
         1'b0, 8'h0, 3'd0, "R8 table unchanged");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_fill;
    t_match;
    t_order;
    t_sample;
    t_retire;
    t_full;
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(CLK_NS * 100000);
    checks++;
    errs++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule